// File: doc/BRIEF.md
# Eight-Bit Arithmetic Logic Unit with Status Flags

This block is the data-processing core of a small eight-bit controller. It takes two operands and an operation code and returns a result. Addition and subtraction, with or without an incoming carry, are supported, as well as decimal correction of a packed BCD sum and bitwise logic. It also provides one-bit rotates, with or without the carry, increment and decrement, and the zero tests that drive conditional skips. The result and the skip decision are combinational. Carry (C), half carry (AC), zero (Z) and overflow (OV) are held in a status register. That register is updated on the clock edge of a valid operation, and only for the flags that the operation defines.

The same status register holds two system flags: a power-down flag (PDF) and a watchdog time-out flag (TO). They change only on system events: clear-watchdog, halt and watchdog expiry. Software can write the arithmetic flags directly, but such a write never reaches PDF or TO. In subtraction, C and AC mean "no borrow". A set carry before SBC therefore means that nothing is to be taken away.

Top module: `alu8_core`

## Requirements
- R1: ADD (op 0) returns opa+opb and ADC (op 1) returns opa+opb+C, both modulo 256. After the edge, C is the carry out of bit 7 and AC is the carry out of bit 3. OV is set when the carry into bit 7 differs from the carry out of it, and Z is set when the result is zero.
- R2: SUB (op 2) returns opa-opb and SBC (op 3) returns opa-opb-(1-C), both modulo 256. C is set when no borrow occurs, so for SUB C=1 exactly when opa>=opb. AC is set when the low nibble needs no borrow. OV flags signed overflow, and Z is set when the result is zero.
- R3: DAA (op 4) works on opa. It adds 06h when the low nibble exceeds 9 or AC is set. It then adds 60h when the intermediate high nibble exceeds 9, when C is set, or when the first step overflowed. C becomes C OR (overflow past 8 bits), Z follows the result, and AC and OV are kept.
- R4: AND (5), OR (6) and XOR (7) combine opa with opb, and CPL (8) returns the complement of opa. They update only Z and keep C, AC and OV.
- R5: RL (9) and RR (10) rotate opa one place left or right within 8 bits and change no flag. RLC (11) and RRC (12) rotate through C: the bit shifted out becomes C, and AC, Z and OV are kept.
- R6: INC (13) and DEC (14) return opa+1 and opa-1 modulo 256. They update only Z.
- R7: For the skip tests, skip is 1 only in these cases: SZ (15) when opa is 0, SNZ (16) when opa is nonzero, and SIZ (17) and SDZ (18) when opa+1 or opa-1 respectively is 0. SZ and SNZ return opa, SIZ and SDZ return the incremented or decremented value, and none of the four alters a flag. For all other codes, skip is 0.
- R8: Status bits are C=0, AC=1, Z=2, OV=3, PDF=4, TO=5, and bits 7:6 read 0. A software write (sw_wr) loads bits 3:0 from sw_wdata[3:0] and leaves PDF and TO unchanged.
- R9: Clear-watchdog clears PDF and TO. Halt sets PDF and clears TO. Watchdog time-out sets TO, and it wins over a same-cycle clear-watchdog or halt for the TO bit. Halt wins over clear-watchdog for PDF.
- R10: Synchronous active-high reset clears the whole status register to 00h.
- R11: With op_valid low, no operation changes the status register, although result and skip still follow the inputs. If sw_wr and op_valid are both high in a cycle, the written value wins for bits 3:0.
- R12: Codes 19 to 31 return opa, give skip 0 and change no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (power-up) |
| op_valid | input | 1 | Commit this cycle's flag results at the clock edge |
| op | input | 5 | Operation code (see requirements) |
| opa | input | 8 | First operand |
| opb | input | 8 | Second operand |
| sw_wr | input | 1 | Software write of the status register |
| sw_wdata | input | 8 | Data for the software write (bits 3:0 used) |
| evt_clrwdt | input | 1 | Clear-watchdog event |
| evt_halt | input | 1 | Halt event |
| evt_wdt_to | input | 1 | Watchdog time-out event |
| result | output | 8 | Combinational operation result |
| skip | output | 1 | Combinational skip decision |
| status | output | 8 | Status register contents |

## Verification
The bench builds the block with its default widths: an 8-bit datapath split into 4-bit nibbles. At this size, every opa value can be swept against an operand-B set that contains 0, 7Fh, 80h, FFh and all repeated-nibble patterns. Each of these is run with both incoming carries, and for DAA with all four C/AC combinations. Expected results and flags come from signed and unsigned integer arithmetic rather than from carry chains. Directed sequences then cover the system-flag events, their precedence, and the priority of a software write over an operation.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    localparam int DW  = 8;
    localparam int NW  = DW / 2;
    localparam int OPW = 5;
    localparam int SW  = 8;
    localparam int FW  = 4;

    localparam int ST_C   = 0;
    localparam int ST_AC  = 1;
    localparam int ST_Z   = 2;
    localparam int ST_OV  = 3;
    localparam int ST_PDF = 4;
    localparam int ST_TO  = 5;

    localparam logic [NW-1:0] BCD_MAX = NW'(9);
    localparam logic [DW:0]   ADJ_LO  = (DW+1)'(6);
    localparam logic [DW:0]   ADJ_HI  = (DW+1)'(96);

    typedef enum logic [OPW-1:0] {
        OP_ADD = 5'd0,  OP_ADC = 5'd1,  OP_SUB = 5'd2,  OP_SBC = 5'd3,
        OP_DAA = 5'd4,  OP_AND = 5'd5,  OP_OR  = 5'd6,  OP_XOR = 5'd7,
        OP_CPL = 5'd8,  OP_RL  = 5'd9,  OP_RR  = 5'd10, OP_RLC = 5'd11,
        OP_RRC = 5'd12, OP_INC = 5'd13, OP_DEC = 5'd14, OP_SZ  = 5'd15,
        OP_SNZ = 5'd16, OP_SIZ = 5'd17, OP_SDZ = 5'd18
    } alu_op_e;

    typedef struct packed {
        logic ov;
        logic z;
        logic ac;
        logic c;
    } flags_t;

    typedef struct packed {
        logic [DW-1:0] res;
        logic          skip;
        flags_t        fl;
        flags_t        upd;
    } alu_res_t;

    typedef struct packed {
        logic [DW-1:0] sum;
        logic          co;
        logic          hc;
        logic          ov;
    } add_t;

    function automatic add_t add_core(input logic [DW-1:0] a,
                                      input logic [DW-1:0] b,
                                      input logic          ci);
        logic [NW:0]   lo;
        logic [DW-1:0] low7;
        logic [DW:0]   full;
        add_t          r;
        lo   = {1'b0, a[NW-1:0]} + {1'b0, b[NW-1:0]} + {{NW{1'b0}}, ci};
        low7 = {1'b0, a[DW-2:0]} + {1'b0, b[DW-2:0]} + {{(DW-1){1'b0}}, ci};
        full = {1'b0, a} + {1'b0, b} + {{DW{1'b0}}, ci};
        r.sum = full[DW-1:0];
        r.co  = full[DW];
        r.hc  = lo[NW];
        r.ov  = low7[DW-1] ^ full[DW];
        return r;
    endfunction

    function automatic logic is_arith(input alu_op_e op);
        return (op == OP_ADD) || (op == OP_ADC) || (op == OP_SUB) ||
               (op == OP_SBC) || (op == OP_DAA);
    endfunction

endpackage

// File: rtl/alu8_arith.sv
module alu8_arith
    import alu8_pkg::*;
(
    input  alu_op_e       op,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  flags_t        fin,
    output alu_res_t      y
);

    logic          is_sub;
    logic [DW-1:0] b_eff;
    logic          c_eff;
    add_t          s;
    logic          lo_adj;
    logic          hi_adj;
    logic [DW:0]   t9;
    logic [DW:0]   r9;

    // Subtraction reuses the adder: a + ~b + carry, carry meaning "no borrow"
    assign is_sub = (op == OP_SUB) || (op == OP_SBC);
    assign b_eff  = is_sub ? ~b : b;

    always_comb begin
        case (op)
            OP_ADD:  c_eff = 1'b0;
            OP_SUB:  c_eff = 1'b1;
            default: c_eff = fin.c;
        endcase
    end

    assign s = add_core(a, b_eff, c_eff);

    // Decimal correction in two steps
    assign lo_adj = (a[NW-1:0] > BCD_MAX) || fin.ac;
    assign t9     = {1'b0, a} + (lo_adj ? ADJ_LO : '0);
    assign hi_adj = (t9[DW-1:NW] > BCD_MAX) || fin.c || t9[DW];
    assign r9     = t9 + (hi_adj ? ADJ_HI : '0);

    always_comb begin
        y      = '0;
        y.res  = a;
        y.fl   = fin;
        case (op)
            OP_ADD, OP_ADC, OP_SUB, OP_SBC: begin
                y.res   = s.sum;
                y.fl.c  = s.co;
                y.fl.ac = s.hc;
                y.fl.ov = s.ov;
                y.fl.z  = (s.sum == '0);
                y.upd   = '{ov: 1'b1, z: 1'b1, ac: 1'b1, c: 1'b1};
            end
            OP_DAA: begin
                y.res   = r9[DW-1:0];
                y.fl.c  = fin.c | r9[DW];
                y.fl.z  = (r9[DW-1:0] == '0);
                y.upd   = '{ov: 1'b0, z: 1'b1, ac: 1'b0, c: 1'b1};
            end
            default: begin
                y.upd   = '0;
            end
        endcase
    end

endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
    import alu8_pkg::*;
(
    input  alu_op_e       op,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  flags_t        fin,
    output alu_res_t      y
);

    logic [DW-1:0] a_inc;
    logic [DW-1:0] a_dec;

    assign a_inc = a + DW'(1);
    assign a_dec = a - DW'(1);

    always_comb begin
        y      = '0;
        y.res  = a;
        y.fl   = fin;
        case (op)
            OP_AND, OP_OR, OP_XOR, OP_CPL, OP_INC, OP_DEC: begin
                case (op)
                    OP_AND:  y.res = a & b;
                    OP_OR:   y.res = a | b;
                    OP_XOR:  y.res = a ^ b;
                    OP_CPL:  y.res = ~a;
                    OP_INC:  y.res = a_inc;
                    default: y.res = a_dec;
                endcase
                y.fl.z  = (y.res == '0);
                y.upd.z = 1'b1;
            end
            OP_RL:  y.res = {a[DW-2:0], a[DW-1]};
            OP_RR:  y.res = {a[0], a[DW-1:1]};
            OP_RLC: begin
                y.res   = {a[DW-2:0], fin.c};
                y.fl.c  = a[DW-1];
                y.upd.c = 1'b1;
            end
            OP_RRC: begin
                y.res   = {fin.c, a[DW-1:1]};
                y.fl.c  = a[0];
                y.upd.c = 1'b1;
            end
            OP_SZ:  y.skip = (a == '0);
            OP_SNZ: y.skip = (a != '0);
            OP_SIZ: begin
                y.res  = a_inc;
                y.skip = (a_inc == '0);
            end
            OP_SDZ: begin
                y.res  = a_dec;
                y.skip = (a_dec == '0);
            end
            default: y.res = a;
        endcase
    end

endmodule

// File: rtl/alu8_status_reg.sv
module alu8_status_reg
    import alu8_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          op_upd,
    input  flags_t        fl_new,
    input  flags_t        fl_mask,
    input  logic          sw_wr,
    input  flags_t        sw_fl,
    input  logic          clrwdt,
    input  logic          halt,
    input  logic          wdt_to,
    output logic [SW-1:0] status
);

    logic [FW-1:0] fl_q;
    logic [FW-1:0] merged;
    logic          pdf_q;
    logic          to_q;

    assign merged = (fl_q & ~fl_mask) | (fl_new & fl_mask);

    always_ff @(posedge clk) begin
        if (rst) begin
            fl_q  <= '0;
            pdf_q <= 1'b0;
            to_q  <= 1'b0;
        end else begin
            if (sw_wr) begin
                fl_q <= sw_fl;
            end else if (op_upd) begin
                fl_q <= merged;
            end

            if (halt) begin
                pdf_q <= 1'b1;
            end else if (clrwdt) begin
                pdf_q <= 1'b0;
            end

            if (wdt_to) begin
                to_q <= 1'b1;
            end else if (halt || clrwdt) begin
                to_q <= 1'b0;
            end
        end
    end

    assign status = {{(SW-ST_TO-1){1'b0}}, to_q, pdf_q, fl_q};

endmodule

// File: rtl/alu8_core.sv
module alu8_core
    import alu8_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           op_valid,
    input  logic [OPW-1:0] op,
    input  logic [DW-1:0]  opa,
    input  logic [DW-1:0]  opb,
    input  logic           sw_wr,
    input  logic [SW-1:0]  sw_wdata,
    input  logic           evt_clrwdt,
    input  logic           evt_halt,
    input  logic           evt_wdt_to,
    output logic [DW-1:0]  result,
    output logic           skip,
    output logic [SW-1:0]  status
);

    alu_op_e  op_e;
    flags_t   fl_cur;
    flags_t   sw_fl;
    alu_res_t y_arith;
    alu_res_t y_logic;
    alu_res_t y_sel;
    logic     unused_wdata_hi;

    assign op_e            = alu_op_e'(op);
    assign fl_cur          = flags_t'(status[FW-1:0]);
    assign sw_fl           = flags_t'(sw_wdata[FW-1:0]);
    assign unused_wdata_hi = ^sw_wdata[SW-1:FW];

    alu8_arith u_arith (
        .op  (op_e),
        .a   (opa),
        .b   (opb),
        .fin (fl_cur),
        .y   (y_arith)
    );

    alu8_logic u_logic (
        .op  (op_e),
        .a   (opa),
        .b   (opb),
        .fin (fl_cur),
        .y   (y_logic)
    );

    assign y_sel  = is_arith(op_e) ? y_arith : y_logic;
    assign result = y_sel.res;
    assign skip   = y_sel.skip;

    alu8_status_reg u_status (
        .clk     (clk),
        .rst     (rst),
        .op_upd  (op_valid),
        .fl_new  (y_sel.fl),
        .fl_mask (y_sel.upd),
        .sw_wr   (sw_wr),
        .sw_fl   (sw_fl),
        .clrwdt  (evt_clrwdt),
        .halt    (evt_halt),
        .wdt_to  (evt_wdt_to),
        .status  (status)
    );

endmodule

// File: rtl/alu8_core_chk.sv
module alu8_core_chk
    import alu8_pkg::*;
(
    input logic           clk,
    input logic           rst,
    input logic           op_valid,
    input logic [OPW-1:0] op,
    input logic [DW-1:0]  opa,
    input logic [DW-1:0]  opb,
    input logic           sw_wr,
    input logic           evt_clrwdt,
    input logic           evt_halt,
    input logic           evt_wdt_to,
    input logic [DW-1:0]  result,
    input logic           skip,
    input logic [SW-1:0]  status
);

    logic no_evt;
    logic logic_op;

    assign no_evt   = !evt_clrwdt && !evt_halt && !evt_wdt_to;
    assign logic_op = (op == OP_AND) || (op == OP_OR) || (op == OP_XOR) || (op == OP_CPL);

    // R2
    sub_no_borrow_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && !sw_wr && op == OP_SUB) |=> status[ST_C] == ($past(opa) >= $past(opb)));

    // R4
    logic_keeps_flags_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && !sw_wr && logic_op) |=>
            (status[ST_C] == $past(status[ST_C])) && (status[ST_AC] == $past(status[ST_AC]))
            && (status[ST_OV] == $past(status[ST_OV])));

    // R4
    logic_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && !sw_wr && logic_op) |=> status[ST_Z] == ($past(result) == '0));

    // R7
    skip_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (op == OP_SZ) |-> skip == (opa == '0));

    // R8
    sw_protect_chk: assert property (@(posedge clk) disable iff (rst)
        (sw_wr && no_evt) |=> status[ST_TO:ST_PDF] == $past(status[ST_TO:ST_PDF]));

    // R9
    wdt_sets_to_chk: assert property (@(posedge clk) disable iff (rst)
        evt_wdt_to |=> status[ST_TO]);

    // R9
    halt_flags_chk: assert property (@(posedge clk) disable iff (rst)
        (evt_halt && !evt_wdt_to) |=> status[ST_PDF] && !status[ST_TO]);

    // R11
    idle_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (!op_valid && !sw_wr && no_evt) |=> $stable(status));

endmodule

bind alu8_core alu8_core_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .op_valid   (op_valid),
    .op         (op),
    .opa        (opa),
    .opb        (opb),
    .sw_wr      (sw_wr),
    .evt_clrwdt (evt_clrwdt),
    .evt_halt   (evt_halt),
    .evt_wdt_to (evt_wdt_to),
    .result     (result),
    .skip       (skip),
    .status     (status)
);

// File: tb/alu8_core_tb.sv
module alu8_core_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       op_valid = 1'b0;
    logic [4:0] op = '0;
    logic [7:0] opa = '0;
    logic [7:0] opb = '0;
    logic       sw_wr = 1'b0;
    logic [7:0] sw_wdata = '0;
    logic       evt_clrwdt = 1'b0;
    logic       evt_halt = 1'b0;
    logic       evt_wdt_to = 1'b0;
    logic [7:0] result;
    logic       skip;
    logic [7:0] status;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    alu8_core u_dut (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op(op), .opa(opa), .opb(opb),
        .sw_wr(sw_wr), .sw_wdata(sw_wdata), .evt_clrwdt(evt_clrwdt), .evt_halt(evt_halt),
        .evt_wdt_to(evt_wdt_to), .result(result), .skip(skip), .status(status)
    );

    task automatic chk(input string tag, input logic [16:0] act, input logic [16:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%05h expected=%05h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    function automatic string tag_of(input int o);
        if (o <= 1) return "R1";
        if (o <= 3) return "R2";
        if (o == 4) return "R3";
        if (o <= 8) return "R4";
        if (o <= 12) return "R5";
        if (o <= 14) return "R6";
        if (o <= 18) return "R7";
        return "R12";
    endfunction

    // Returns {result, skip, status} expected with PDF and TO clear
    function automatic logic [16:0] model(input int o, input int a, input int b, input logic [3:0] pre);
        int c, ac, z, ov, r, sk, s, sa, sb, ss, bw, ci, t, hi;
        c = pre[0]; ac = pre[1]; z = pre[2]; ov = pre[3];
        r = a; sk = 0;
        sa = (a > 127) ? a - 256 : a;
        sb = (b > 127) ? b - 256 : b;
        case (o)
            0, 1: begin
                ci = (o == 1) ? c : 0;
                s  = a + b + ci;
                ss = sa + sb + ci;
                ac = ((a % 16) + (b % 16) + ci) > 15;
                c  = s > 255;
                ov = (ss > 127) || (ss < -128);
                r  = s % 256;
                z  = (r == 0);
            end
            2, 3: begin
                bw = (o == 2) ? 0 : 1 - c;
                s  = a - b - bw;
                ss = sa - sb - bw;
                ac = ((a % 16) - (b % 16) - bw) >= 0;
                c  = s >= 0;
                ov = (ss > 127) || (ss < -128);
                r  = (s + 256) % 256;
                z  = (r == 0);
            end
            4: begin
                t  = a + ((((a % 16) > 9) || ac) ? 6 : 0);
                hi = (((t / 16) % 16) > 9) || c || (t > 255);
                s  = t + (hi ? 96 : 0);
                c  = c || (s > 255);
                r  = s % 256;
                z  = (r == 0);
            end
            5:  begin r = a & b;   z = (r == 0); end
            6:  begin r = a | b;   z = (r == 0); end
            7:  begin r = a ^ b;   z = (r == 0); end
            8:  begin r = 255 - a; z = (r == 0); end
            9:  r = (a * 2) % 256 + a / 128;
            10: r = a / 2 + (a % 2) * 128;
            11: begin r = (a * 2) % 256 + c; c = a / 128; end
            12: begin r = a / 2 + c * 128;   c = a % 2;   end
            13: begin r = (a + 1) % 256;   z = (r == 0); end
            14: begin r = (a + 255) % 256; z = (r == 0); end
            15: sk = (a == 0);
            16: sk = (a != 0);
            17: begin r = (a + 1) % 256;   sk = (r == 0); end
            18: begin r = (a + 255) % 256; sk = (r == 0); end
            default: r = a;
        endcase
        return {r[7:0], sk[0], 4'b0000, ov[0], z[0], ac[0], c[0]};
    endfunction

    task automatic run_vec(input int o, input int a, input int b, input logic [3:0] pre);
        logic [7:0] r_cap;
        logic       s_cap;
        sw_wr = 1'b1; sw_wdata = {4'h0, pre}; op_valid = 1'b0;
        tick();
        sw_wr = 1'b0; op_valid = 1'b1;
        op = 5'(o); opa = 8'(a); opb = 8'(b);
        #1;
        r_cap = result; s_cap = skip;
        tick();
        op_valid = 1'b0;
        chk(tag_of(o), {r_cap, s_cap, status}, model(o, a, b, pre));
    endtask

    function automatic int b_pick(input int bi);
        if (bi < 16) return bi * 17;
        if (bi == 16) return 128;
        return 127;
    endfunction

    task automatic status_chk(input string tag, input logic [7:0] exp);
        chk(tag, {9'h000, status}, {9'h000, exp});
    endtask

    initial begin
        logic [7:0] r_hold;
        repeat (3) tick();
        rst = 1'b0;
        // R10 reset state
        status_chk("R10", 8'h00);

        // R1 R2: add and subtract families
        for (int o = 0; o < 4; o++)
            for (int a = 0; a < 256; a++)
                for (int bi = 0; bi < 18; bi++)
                    for (int ci = 0; ci < 2; ci++) begin
                        int b;
                        b = b_pick(bi);
                        run_vec(o, a, b, {a[0] ^ b[7], b[3], a[5], ci[0]});
                    end

        // R3: decimal adjust under every C/AC pair
        for (int a = 0; a < 256; a++)
            for (int k = 0; k < 4; k++)
                run_vec(4, a, 0, {a[6], a[1], k[1], k[0]});

        // R4: bitwise logic
        for (int o = 5; o < 9; o++)
            for (int a = 0; a < 256; a++)
                for (int bi = 0; bi < 18; bi++) begin
                    int b;
                    b = b_pick(bi);
                    run_vec(o, a, b, {a[2] ^ b[1], a[7], b[4], a[0]});
                end

        // R5 R6 R7: rotates, inc/dec and skip tests
        for (int o = 9; o < 19; o++)
            for (int a = 0; a < 256; a++)
                for (int ci = 0; ci < 2; ci++)
                    run_vec(o, a, 8'h5A, {a[3], a[4] ^ ci[0], ~a[1], ci[0]});

        // R12: unused codes
        for (int o = 19; o < 32; o++)
            for (int k = 0; k < 4; k++)
                run_vec(o, k * 85, 8'h33, 4'(k * 5));

        // R8 R9 R11: status register events and priorities
        sw_wr = 1'b1; sw_wdata = 8'h05; tick(); sw_wr = 1'b0;
        status_chk("R8", 8'h05);
        evt_halt = 1'b1; tick(); evt_halt = 1'b0;
        status_chk("R9", 8'h15);
        evt_wdt_to = 1'b1; tick(); evt_wdt_to = 1'b0;
        status_chk("R9", 8'h35);
        sw_wr = 1'b1; sw_wdata = 8'hC0; tick(); sw_wr = 1'b0;
        status_chk("R8", 8'h30);
        sw_wr = 1'b1; sw_wdata = 8'hFF; tick(); sw_wr = 1'b0;
        status_chk("R8", 8'h3F);
        evt_clrwdt = 1'b1; tick(); evt_clrwdt = 1'b0;
        status_chk("R9", 8'h0F);
        evt_clrwdt = 1'b1; evt_wdt_to = 1'b1; tick(); evt_clrwdt = 1'b0; evt_wdt_to = 1'b0;
        status_chk("R9", 8'h2F);
        evt_halt = 1'b1; evt_clrwdt = 1'b1; tick(); evt_halt = 1'b0; evt_clrwdt = 1'b0;
        status_chk("R9", 8'h1F);
        sw_wr = 1'b1; sw_wdata = 8'h00; tick(); sw_wr = 1'b0;
        status_chk("R8", 8'h10);

        op_valid = 1'b0; op = 5'd0; opa = 8'hFF; opb = 8'h01;
        #1; r_hold = result;
        tick(); tick();
        chk("R11", {r_hold, 1'b0, status}, {8'h00, 1'b0, 8'h10});
        op_valid = 1'b1; sw_wr = 1'b1; sw_wdata = 8'h0A;
        tick();
        op_valid = 1'b0; sw_wr = 1'b0;
        status_chk("R11", 8'h1A);

        rst = 1'b1; tick(); rst = 1'b0;
        status_chk("R10", 8'h00);
        evt_halt = 1'b1; evt_wdt_to = 1'b1; tick(); evt_halt = 1'b0; evt_wdt_to = 1'b0;
        status_chk("R9", 8'h30);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule